// File: doc/BRIEF.md
# Serial Two-Wire Memory Read Engine

This block is the read side of a small two-wire serial memory slave. A 128-word by 8-bit register file sits behind an I2C-style bus front end. The front end oversamples SCL and SDA with the system clock, finds start and stop conditions, matches a 7-bit device address and then streams memory words to the bus master, MSB first. After each byte the master's acknowledge decides whether another byte follows. An internal word pointer advances by one per byte sent and wraps over the whole array, so a single transaction can stream every word.

A master selects the starting word in one of two ways. It can write one word-address byte, send a repeated start and then switch to the read direction. Or it can simply open a read, which continues from where the last access stopped. The slave pulls SDA low only through an open-drain enable output. A side port loads the array, so tests and boot code can fill it.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: A start condition (SDA falling while SCL is high) restarts address reception from any state. A stop condition (SDA rising while SCL is high) returns the slave to idle. A repeated start straight after a write-direction address header leaves the word pointer unchanged.
- R2: The first byte after a start is read as a 7-bit device address, MSB first, followed by a direction bit (1 = read). Only a match to parameter DEV_ADDR (default 7'h50) is acknowledged, by pulling SDA low during the ninth clock. On a mismatch SDA stays released and the bus is ignored until the next start.
- R3: After an acknowledged write-direction address, the next byte's low 7 bits load the word pointer (bit 7 is ignored) and the byte is acknowledged. Any further write byte is not acknowledged. A repeated start and a read header then return the word at the loaded address.
- R4: A read opened without a word-address phase begins at the pointer value left behind by the previous read, which is the last sent address plus one, modulo 128.
- R5: Data bits leave MSB first. The open-drain enable is high exactly when a 0 is sent or an acknowledge is given, and it changes only while SCL is low.
- R6: When the master acknowledges a data byte, the next byte comes from the next address, so a stream from address n gives n, n+1, n+2, and so on.
- R7: After the word at address 127 is sent, the pointer wraps to 0 and the stream continues there. A single read can stream the whole array and more.
- R8: When the master does not acknowledge, the slave releases SDA for all further clocks until a start, and the pointer stays at the address after the last word sent.
- R9: The slave keeps SDA released during the master's acknowledge bit.
- R10: A side-port write updates the array one clock later. If it lands in the same clock as a word load into the output shifter, the byte on the bus carries the old contents, and later reads see the new value.
- R11: After reset the open-drain enable is low and the word pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level as seen at the pad |
| sda_in | input | 1 | Bus data level as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |
| pre_we | input | 1 | Side-port write strobe |
| pre_addr | input | 7 | Side-port word address |
| pre_data | input | 8 | Side-port write data |

## Verification
Two functions can fall in the same system clock: a side-port write and the load of the next word into the output shifter, which happens on the synchronized SCL fall that ends the master's acknowledge. The bench counts the synchronizer stages from its own SCL falling edge. It raises the write strobe on exactly the clock in which the engine loads the word, aimed at the address being loaded. The byte on the bus must carry the old contents. A fresh random read of that address must then return the new value.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_WORDADR,
    ST_WORDACK,
    ST_SEND,
    ST_HOSTACK,
    ST_IGNORE
  } rd_state_e;

endpackage

// File: rtl/bus_sampler.sv
module bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic                   scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[SYNC_STAGES-1];
      sda_q    <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_hi    = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_hi & ~scl_q;
  assign scl_fall  = ~scl_hi & scl_q;
  assign start_det = scl_hi & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_hi & scl_q & ~sda_q & sda_lvl;

  // R1
  start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !stop_det);

endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[wa] <= wd;
    end
  end

  assign rd = cells[ra];

  // R10
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa == ra) |=> (ra != $past(ra) || rd == $past(wd)));

endmodule

// File: rtl/rd_engine.sv
module rd_engine
  import eerd_pkg::*;
#(
  parameter int          AW       = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_hi,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              sda_oe
);

  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  rd_state_e         st, st_n;
  logic [3:0]        cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic [AW-1:0]     ctr, ctr_n;
  logic              oe, oe_n;
  logic              is_read, is_read_n;
  logic              ack, ack_n;

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    sh_n      = sh;
    ctr_n     = ctr;
    oe_n      = oe;
    is_read_n = is_read;
    ack_n     = ack;
    if (start_det) begin
      st_n  = ST_DEVADR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st)
        ST_DEVADR: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_lvl};
            cnt_n = 4'(cnt + 4'd1);
          end
          if (scl_fall && cnt == LAST_BIT) begin
            if (sh[BYTE_W-1:1] == DEV_ADDR) begin
              st_n      = ST_DEVACK;
              oe_n      = 1'b1;
              is_read_n = sh[0];
            end else begin
              st_n = ST_IGNORE;
            end
          end
        end
        ST_DEVACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (is_read) begin
              st_n = ST_SEND;
              sh_n = rd_data;
              oe_n = ~rd_data[BYTE_W-1];
            end else begin
              st_n = ST_WORDADR;
              oe_n = 1'b0;
            end
          end
        end
        ST_WORDADR: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_lvl};
            cnt_n = 4'(cnt + 4'd1);
          end
          if (scl_fall && cnt == LAST_BIT) begin
            ctr_n = sh[AW-1:0];
            st_n  = ST_WORDACK;
            oe_n  = 1'b1;
          end
        end
        ST_WORDACK: begin
          if (scl_fall) begin
            st_n = ST_IGNORE;
            oe_n = 1'b0;
          end
        end
        ST_SEND: begin
          if (scl_rise) begin
            cnt_n = 4'(cnt + 4'd1);
          end
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              st_n  = ST_HOSTACK;
              oe_n  = 1'b0;
              ctr_n = AW'(ctr + 1'b1);
            end else begin
              sh_n = {sh[BYTE_W-2:0], 1'b0};
              oe_n = ~sh[BYTE_W-2];
            end
          end
        end
        ST_HOSTACK: begin
          if (scl_rise) begin
            ack_n = ~sda_lvl;
          end
          if (scl_fall) begin
            if (ack) begin
              st_n  = ST_SEND;
              cnt_n = '0;
              sh_n  = rd_data;
              oe_n  = ~rd_data[BYTE_W-1];
            end else begin
              st_n = ST_IGNORE;
              oe_n = 1'b0;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      ctr     <= '0;
      oe      <= 1'b0;
      is_read <= 1'b0;
      ack     <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      sh      <= sh_n;
      ctr     <= ctr_n;
      oe      <= oe_n;
      is_read <= is_read_n;
      ack     <= ack_n;
    end
  end

  assign rd_addr = ctr;
  assign sda_oe  = oe;

  // R5
  oe_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> !scl_hi);

  // R9
  hostack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOSTACK) |-> !oe);

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_DEVADR && cnt == 4'd0 && !oe));

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !oe);

  // R6
  next_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOSTACK && scl_fall && ack) |=> (st == ST_SEND && sh == $past(rd_data)));

endmodule

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader #(
  parameter int         AW          = 7,
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_data
);

  logic          scl_hi, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  word_store #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(pre_we), .wa(pre_addr), .wd(pre_data),
    .ra(rd_addr), .rd(rd_data)
  );

  rd_engine #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .rd_addr(rd_addr),
    .sda_oe(sda_oe)
  );

endmodule

// File: tb/tb_i2c_eeprom_reader.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_reader;

  localparam int         PH  = 8;
  localparam logic [6:0] DEV = 7'h50;
  // {word-address byte, byte count}
  localparam logic [15:0] VECS [7] = '{16'h0501, 16'h0003, 16'h7804,
                                       16'h7E05, 16'h8502, 16'h7F02, 16'h4003};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_in, m_low, pre_we;
  logic [6:0] pre_addr;
  logic [7:0] pre_data;
  logic       sda_oe;
  wire        sda_bus = ~(m_low | sda_oe);

  int   total = 0, bad = 0, oe_hi_changes = 0;
  bit   done = 1'b0;
  logic [7:0] model [128];
  int   ptr = 0;

  i2c_eeprom_reader dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_bus),
    .sda_oe(sda_oe), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  always #2.5 clk = ~clk;

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != prev_oe && scl_in) oe_hi_changes++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start;
    m_low = 1'b0; tick(PH);
    scl_in = 1'b1; tick(PH);
    m_low = 1'b1; tick(PH);
    scl_in = 1'b0; tick(2);
  endtask

  task automatic do_stop;
    m_low = 1'b1; tick(PH);
    scl_in = 1'b1; tick(PH);
    m_low = 1'b0; tick(PH);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(PH);
      scl_in = 1'b1; tick(PH);
      scl_in = 1'b0; tick(2);
    end
    m_low = 1'b0; tick(PH);
    scl_in = 1'b1; tick(PH/2);
    ack = ~sda_bus; tick(PH/2);
    scl_in = 1'b0; tick(2);
  endtask

  task automatic read_byte(input bit give_ack, input bit collide,
                           input logic [6:0] ca, input logic [7:0] cd,
                           output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(PH);
      scl_in = 1'b1; tick(PH/2);
      b[i] = sda_bus; tick(PH/2);
      scl_in = 1'b0; tick(2);
    end
    m_low = give_ack; tick(PH);
    scl_in = 1'b1; tick(PH/2);
    // R9: slave leaves SDA released while the master answers
    if (!give_ack) chk(sda_bus == 1'b1, "R9", sda_bus, 1);
    tick(PH/2);
    scl_in = 1'b0; tick(1);
    m_low = 1'b0; tick(1);
    if (collide) begin
      pre_we = 1'b1; pre_addr = ca; pre_data = cd;
    end
    tick(1);
    pre_we = 1'b0;
  endtask

  task automatic read_stream(input int n, input int first, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      read_byte(k < n - 1, 1'b0, 7'd0, 8'd0, b);
      chk(b == model[(first + k) % 128], req, b, model[(first + k) % 128]);
    end
    ptr = (first + n) % 128;
  endtask

  task automatic rand_read(input logic [7:0] wa, input int n, input string req);
    bit ack;
    do_start;
    write_byte({DEV, 1'b0}, ack); chk(ack, "R2", ack, 1);
    write_byte(wa, ack);          chk(ack, "R3", ack, 1);
    do_start;
    write_byte({DEV, 1'b1}, ack); chk(ack, "R2", ack, 1);
    read_stream(n, int'(wa[6:0]), req);
    do_stop;
  endtask

  task automatic cur_read(input int n, input string req);
    bit ack;
    do_start;
    write_byte({DEV, 1'b1}, ack); chk(ack, "R2", ack, 1);
    read_stream(n, ptr, req);
    do_stop;
  endtask

  initial begin
    tick(190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    rst_n = 1'b0; scl_in = 1'b1; m_low = 1'b0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    tick(4);
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);
    rst_n = 1'b1; tick(2);
    chk(sda_oe == 1'b0, "R11", sda_oe, 0);

    for (int a = 0; a < 128; a++) begin
      model[a] = 8'((a * 29 + 7) & 255);
      pre_we = 1'b1; pre_addr = 7'(a); pre_data = model[a]; tick(1);
    end
    pre_we = 1'b0; tick(2);

    // R11, R4: pointer starts at 0 after reset
    cur_read(1, "R11");

    // R3, R6, R7: table of random reads (0x85 checks bit 7 ignored, 0x7E wraps)
    foreach (VECS[v]) rand_read(VECS[v][15:8], int'(VECS[v][7:0]), "R6");

    // R4: continue after the last random read
    cur_read(2, "R4");

    // R2: wrong device address is ignored, pointer untouched
    do_start;
    write_byte({DEV ^ 7'h01, 1'b1}, ack); chk(!ack, "R2", ack, 0);
    read_byte(1'b0, 1'b0, 7'd0, 8'd0, b); chk(b == 8'hFF, "R2", b, 8'hFF);
    do_stop;
    cur_read(1, "R2");

    // R8: after a not-acknowledge SDA stays released, pointer at next word
    do_start;
    write_byte({DEV, 1'b1}, ack); chk(ack, "R2", ack, 1);
    read_stream(1, ptr, "R8");
    read_byte(1'b0, 1'b0, 7'd0, 8'd0, b); chk(b == 8'hFF, "R8", b, 8'hFF);
    do_stop;
    cur_read(1, "R8");

    // R1: repeated start right after a write header keeps the pointer
    do_start;
    write_byte({DEV, 1'b0}, ack); chk(ack, "R1", ack, 1);
    do_start;
    write_byte({DEV, 1'b1}, ack); chk(ack, "R1", ack, 1);
    read_stream(1, ptr, "R1");
    do_stop;

    // R3: extra write byte after the word address is not acknowledged
    do_start;
    write_byte({DEV, 1'b0}, ack);
    write_byte(8'd20, ack); chk(ack, "R3", ack, 1);
    write_byte(8'h3C, ack); chk(!ack, "R3", ack, 0);
    do_stop;
    ptr = 20;
    cur_read(1, "R3");

    // R7: stream the whole array plus two words past the wrap
    rand_read(8'd0, 130, "R7");

    // R10: side write collides with the load of word 41
    do_start;
    write_byte({DEV, 1'b0}, ack);
    write_byte(8'd40, ack);
    do_start;
    write_byte({DEV, 1'b1}, ack);
    read_byte(1'b1, 1'b1, 7'd41, 8'hA5, b); chk(b == model[40], "R10", b, model[40]);
    read_byte(1'b0, 1'b0, 7'd0, 8'd0, b);   chk(b == model[41], "R10", b, model[41]);
    do_stop;
    model[41] = 8'hA5;
    rand_read(8'd41, 1, "R10");

    // R5: enable never moved while SCL was high
    chk(oe_hi_changes == 0, "R5", oe_hi_changes, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule